// File: doc/BRIEF.md
# Asynchronous Memory Access Phase Timer

This block sequences the control strobes of a single asynchronous access to a NAND flash or PC Card style memory. When it accepts a start request, it captures one of three timing sets: one for common memory, one for attribute memory and one for I/O space. It then runs three phases, each lasting a programmed number of bus clock cycles. Chip enable covers all three phases. The read or write strobe is active only in the middle phase. For a write, the data-output enable switches on after its own programmed delay and stays on until the access ends.

A bus controller calls the block once per memory transaction. It supplies the direction, the space code and a mode bit that tells PC Card operation from NAND operation. It then waits for the one-cycle done pulse that ends the transaction. A request is ignored if it arrives while an access is running, if it names the I/O space in NAND mode, or if it uses the reserved space code.

Top module: `mem_phase_timer`

## Requirements
- R1: After reset all outputs are low. A start request is accepted only while no access is running. The first setup cycle then follows in the next clock cycle.
- R2: An accepted access runs its phases in the order setup, then strobe, then hold. A programmed value N gives N+1 cycles. The fields of a 32-bit timing word are setup in [7:0], strobe in [15:8], hold in [23:16] and data-drive delay in [31:24].
- R3: During the strobe phase `rd_o` is high for a read (`write_i`=0) and `wr_o` is high for a write (`write_i`=1). Neither strobe is high outside that phase, and the two are never high together.
- R4: The space code picks the timing word: 0 = common word, 1 = attribute word, 2 = I/O word. Only the picked word affects the access.
- R5: A request with space code 2 while `pccard_i`=0 (NAND mode) is ignored, and so is a request with space code 3. No output changes.
- R6: For a write, `dout_en_o` rises in cycle index D of the access, where D is the drive field and cycle index 0 is the first setup cycle. It stays high through the last hold cycle. If D is not less than the access length, it never rises. It never rises during a read.
- R7: `ce_o` is high from the first setup cycle to the last hold cycle inclusive, and low at all other times.
- R8: A one-cycle `done_o` pulse follows the last hold cycle, with `ce_o` low.
- R9: A start request that arrives during an access, including its done cycle, is ignored.
- R10: The timing word and the direction are captured when a request is accepted. Input changes during the access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Access request pulse |
| write_i | input | 1 | 1 = write, 0 = read |
| space_i | input | 2 | Space code: 0 common, 1 attribute, 2 I/O, 3 reserved |
| pccard_i | input | 1 | 1 = PC Card mode, 0 = NAND mode |
| tim_common_i | input | 32 | Timing word for common memory |
| tim_attr_i | input | 32 | Timing word for attribute memory |
| tim_io_i | input | 32 | Timing word for I/O space |
| ce_o | output | 1 | Chip enable, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| dout_en_o | output | 1 | Write data-bus drive enable |
| done_o | output | 1 | One-cycle end-of-access pulse |

## Verification
A wrong phase state or a wrong counter load shows at once as a misplaced strobe edge or a wrong chip-enable length. The monitor catches this when the access closes, by comparing the measured setup, strobe and hold lengths with the expected ones. A wrong elapsed count, or a wrong drive delay, shows as a shifted or truncated data-enable window in the same access. A bad acceptance decision shows up in one of two ways. An extra access appears that the scoreboard cannot match, or an expected access never appears and is caught by the final access count.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
    localparam int PHASE_W = 8;
    localparam int TSET_W  = 4 * PHASE_W;
    localparam int ELAP_W  = PHASE_W + 2;

    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_IO     = 2'd2,
        SP_RSVD   = 2'd3
    } space_e;

    typedef struct packed {
        logic [PHASE_W-1:0] drive;
        logic [PHASE_W-1:0] hold;
        logic [PHASE_W-1:0] strobe;
        logic [PHASE_W-1:0] setup;
    } tset_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } phase_e;

    function automatic logic space_allowed(space_e sp, logic pccard);
        case (sp)
            SP_COMMON, SP_ATTR: return 1'b1;
            SP_IO:              return pccard;
            default:            return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mpt_set_select.sv
module mpt_set_select
    import mpt_pkg::*;
#(
    parameter int NUM_SETS = 3
) (
    input  logic [1:0]  space_i,
    input  logic        pccard_i,
    input  tset_t       sets_i [NUM_SETS],
    output tset_t       sel_o,
    output logic        ok_o
);
    localparam int IDX_W = $clog2(NUM_SETS);

    logic [IDX_W-1:0] idx;

    always_comb begin
        ok_o  = space_allowed(space_e'(space_i), pccard_i);
        idx   = space_i[IDX_W-1:0];
        sel_o = '0;
        if (ok_o && (32'(space_i) < NUM_SETS)) begin
            sel_o = sets_i[idx];
        end
    end
endmodule

// File: rtl/mpt_phase_seq.sv
module mpt_phase_seq
    import mpt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   accept_i,
    input  tset_t  start_set_i,
    input  tset_t  held_set_i,
    input  logic   write_q_i,
    output logic   busy_o,
    output logic   ce_o,
    output logic   rd_o,
    output logic   wr_o,
    output logic   done_o
);
    phase_e             st_q;
    logic [PHASE_W-1:0] cnt_q;
    logic               last_cycle;

    assign last_cycle = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept_i) begin
                        st_q  <= ST_SETUP;
                        cnt_q <= start_set_i.setup;
                    end
                end
                ST_SETUP: begin
                    if (last_cycle) begin
                        st_q  <= ST_STROBE;
                        cnt_q <= held_set_i.strobe;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_STROBE: begin
                    if (last_cycle) begin
                        st_q  <= ST_HOLD;
                        cnt_q <= held_set_i.hold;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (last_cycle) begin
                        st_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (st_q != ST_IDLE);
    assign ce_o   = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
    assign rd_o   = (st_q == ST_STROBE) && !write_q_i;
    assign wr_o   = (st_q == ST_STROBE) && write_q_i;
    assign done_o = (st_q == ST_DONE);

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_o, wr_o})); // R3
    AST_STROBE_INSIDE_CE: assert property (@(posedge clk) disable iff (rst)
        (rd_o || wr_o) |-> ce_o); // R7
    AST_STROBE_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_STROBE) |=> (st_q == ST_STROBE || st_q == ST_HOLD)); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R8
    AST_DONE_CE_LOW: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !ce_o); // R8
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DONE) |=> !ce_o); // R9
endmodule

// File: rtl/mpt_drive_gate.sv
module mpt_drive_gate
    import mpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept_i,
    input  logic               active_i,
    input  logic               write_q_i,
    input  logic [PHASE_W-1:0] drive_q_i,
    output logic               dout_en_o
);
    localparam logic [ELAP_W-1:0] ELAP_MAX = '1;

    logic [ELAP_W-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            elapsed_q <= '0;
        end else if (accept_i) begin
            elapsed_q <= '0;
        end else if (active_i && elapsed_q != ELAP_MAX) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    assign dout_en_o = active_i && write_q_i &&
                       (ELAP_W'(drive_q_i) <= elapsed_q);

    AST_DOUT_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        dout_en_o |-> (active_i && write_q_i)); // R6
    AST_DOUT_STAYS_ON: assert property (@(posedge clk) disable iff (rst)
        (dout_en_o && !accept_i) |=> (dout_en_o || !active_i)); // R6
endmodule

// File: rtl/mem_phase_timer.sv
module mem_phase_timer
    import mpt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        write_i,
    input  logic [1:0]  space_i,
    input  logic        pccard_i,
    input  logic [31:0] tim_common_i,
    input  logic [31:0] tim_attr_i,
    input  logic [31:0] tim_io_i,
    output logic        ce_o,
    output logic        rd_o,
    output logic        wr_o,
    output logic        dout_en_o,
    output logic        done_o
);
    localparam int NUM_SETS = 3;

    tset_t sets [NUM_SETS];
    tset_t sel_set;
    tset_t set_q;
    logic  sel_ok;
    logic  busy;
    logic  accept;
    logic  write_q;

    assign sets[SP_COMMON] = tset_t'(tim_common_i);
    assign sets[SP_ATTR]   = tset_t'(tim_attr_i);
    assign sets[SP_IO]     = tset_t'(tim_io_i);

    mpt_set_select #(.NUM_SETS(NUM_SETS)) u_select (
        .space_i  (space_i),
        .pccard_i (pccard_i),
        .sets_i   (sets),
        .sel_o    (sel_set),
        .ok_o     (sel_ok)
    );

    assign accept = start_i && !busy && sel_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            set_q   <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            set_q   <= sel_set;
            write_q <= write_i;
        end
    end

    mpt_phase_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .start_set_i (sel_set),
        .held_set_i  (set_q),
        .write_q_i   (write_q),
        .busy_o      (busy),
        .ce_o        (ce_o),
        .rd_o        (rd_o),
        .wr_o        (wr_o),
        .done_o      (done_o)
    );

    mpt_drive_gate u_drive (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .active_i  (ce_o),
        .write_q_i (write_q),
        .drive_q_i (set_q.drive),
        .dout_en_o (dout_en_o)
    );

    AST_ACCEPT_STARTS_CE: assert property (@(posedge clk) disable iff (rst)
        accept |=> ce_o); // R1
    AST_REJECT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> !ce_o); // R5
endmodule

// File: tb/test_mem_phase_timer.sv
`timescale 1ns/100ps
module test_mem_phase_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic [1:0]  space_i = 2'd0;
    logic        pccard_i = 1'b0;
    logic [31:0] tim_common_i = '0;
    logic [31:0] tim_attr_i = '0;
    logic [31:0] tim_io_i = '0;
    logic        ce_o, rd_o, wr_o, dout_en_o, done_o;

    always #2.5 clk = ~clk;

    mem_phase_timer i_mem_phase_timer (
        .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
        .space_i(space_i), .pccard_i(pccard_i), .tim_common_i(tim_common_i),
        .tim_attr_i(tim_attr_i), .tim_io_i(tim_io_i), .ce_o(ce_o), .rd_o(rd_o),
        .wr_o(wr_o), .dout_en_o(dout_en_o), .done_o(done_o)
    );

    typedef struct {
        int setup_len;
        int strobe_len;
        int hold_len;
        bit is_write;
        int dout_first;
        int dout_cnt;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    int n_acc = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor
    bit in_acc = 0;
    int k, fs, sc, rdc, wrc, df, dc;
    always @(negedge clk) begin
        if (rst) begin
            in_acc = 0;
        end else if (ce_o) begin
            if (!in_acc) begin
                in_acc = 1; k = 0; fs = -1; sc = 0; rdc = 0; wrc = 0; df = -1; dc = 0;
            end
            if (rd_o) rdc++;
            if (wr_o) wrc++;
            if ((rd_o || wr_o) && fs < 0) fs = k;
            if (rd_o || wr_o) sc++;
            if (dout_en_o) begin
                if (df < 0) df = k;
                dc++;
            end
            k++;
        end else if (in_acc) begin
            exp_t e;
            in_acc = 0;
            n_acc++;
            check(done_o == 1'b1, "R8", "done after hold", int'(done_o), 1);
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "unexpected access", n_acc, n_acc - 1);
            end else begin
                e = exp_q.pop_front();
                check(fs == e.setup_len, "R2", "setup length", fs, e.setup_len);
                check(sc == e.strobe_len, "R2", "strobe length", sc, e.strobe_len);
                check(k - fs - sc == e.hold_len, "R2", "hold length",
                      k - fs - sc, e.hold_len);
                check(k == e.setup_len + e.strobe_len + e.hold_len, "R7",
                      "ce length", k, e.setup_len + e.strobe_len + e.hold_len);
                check(rdc == (e.is_write ? 0 : e.strobe_len), "R3", "rd cycles",
                      rdc, e.is_write ? 0 : e.strobe_len);
                check(wrc == (e.is_write ? e.strobe_len : 0), "R3", "wr cycles",
                      wrc, e.is_write ? e.strobe_len : 0);
                check(df == e.dout_first, "R6", "dout first index", df, e.dout_first);
                check(dc == e.dout_cnt, "R6", "dout cycles", dc, e.dout_cnt);
            end
        end
    end

    // driver: mode 0 plain, 1 start again mid-access, 2 start again in done cycle
    task automatic run_access(input bit wr, input logic [1:0] sp, input bit pc,
                              input int s, input int w, input int h, input int d,
                              input bit expect_ok, input int mode);
        logic [31:0] word;
        logic [31:0] other;
        int total;
        exp_t e;
        word  = {8'(d), 8'(h), 8'(w), 8'(s)};
        other = {8'd1, 8'd9, 8'd6, 8'd4};
        total = s + w + h + 3;
        tim_common_i = (sp == 2'd0) ? word : other;
        tim_attr_i   = (sp == 2'd1) ? word : other;
        tim_io_i     = (sp == 2'd2) ? word : other;
        write_i  = wr;
        space_i  = sp;
        pccard_i = pc;
        if (expect_ok) begin
            e.setup_len  = s + 1;
            e.strobe_len = w + 1;
            e.hold_len   = h + 1;
            e.is_write   = wr;
            e.dout_first = (wr && d < total) ? d : -1;
            e.dout_cnt   = (wr && d < total) ? total - d : 0;
            exp_q.push_back(e);
        end
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (mode == 1) begin
            @(negedge clk);
            // R10: changed inputs and a new request mid-access must not matter
            tim_common_i = 32'h0;
            tim_attr_i   = 32'h0;
            tim_io_i     = 32'h0;
            write_i      = ~wr;
            space_i      = 2'd0;
            start_i      = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            repeat (total + 2) @(negedge clk);
        end else if (mode == 2) begin
            repeat (total) @(negedge clk);
            space_i = 2'd0;
            start_i = 1'b1;  // lands in the done cycle: R9
            @(negedge clk);
            start_i = 1'b0;
            repeat (total + 4) @(negedge clk);
        end else begin
            repeat (total + 3) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int acc_before;
        int expected_total;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(ce_o == 0, "R1", "ce after reset", int'(ce_o), 0);
        check({rd_o, wr_o, dout_en_o, done_o} == 4'b0, "R1", "outputs after reset",
              int'({rd_o, wr_o, dout_en_o, done_o}), 0);

        run_access(1'b0, 2'd0, 1'b0, 0, 0, 0, 0, 1'b1, 0);   // R2 minimum, read
        run_access(1'b0, 2'd0, 1'b0, 2, 5, 3, 0, 1'b1, 0);   // R3 read, R6 no dout
        run_access(1'b1, 2'd1, 1'b0, 3, 4, 2, 5, 1'b1, 0);   // R4 attr, R6 mid delay
        run_access(1'b1, 2'd2, 1'b1, 1, 2, 1, 0, 1'b1, 0);   // R4 io in pc card, d=0
        run_access(1'b1, 2'd0, 1'b0, 1, 1, 1, 6, 1'b1, 0);   // R6 d == total -> never
        run_access(1'b1, 2'd1, 1'b0, 1, 1, 1, 5, 1'b1, 0);   // R6 d = last cycle
        run_access(1'b0, 2'd1, 1'b0, 0, 255, 0, 0, 1'b1, 0); // R2 long strobe

        acc_before = n_acc;
        run_access(1'b1, 2'd2, 1'b0, 1, 1, 1, 0, 1'b0, 0);   // R5 io in NAND
        check(n_acc == acc_before, "R5", "io in NAND ignored", n_acc, acc_before);
        check(ce_o == 0, "R5", "ce low after ignored io", int'(ce_o), 0);
        acc_before = n_acc;
        run_access(1'b0, 2'd3, 1'b1, 1, 1, 1, 0, 1'b0, 0);   // R5 reserved code
        check(n_acc == acc_before, "R5", "reserved space ignored", n_acc, acc_before);

        run_access(1'b1, 2'd0, 1'b0, 4, 3, 2, 2, 1'b1, 1);   // R9 R10 restart mid-access
        run_access(1'b0, 2'd1, 1'b0, 1, 2, 1, 0, 1'b1, 2);   // R9 restart in done cycle

        expected_total = 9;
        check(n_acc == expected_total, "R9", "access count", n_acc, expected_total);
        check(exp_q.size() == 0, "R1", "all expected accesses seen", exp_q.size(), 0);
        finish_run();
    end
endmodule